// File: doc/BRIEF.md
# Inbound Host Cycle Address Window Decoder

This block decides, for each inbound host cycle, whether the cycle falls inside one of several address windows that software programs, and which window that is. Every window has an inclusive start and end address, an enable flag, and its own permission flags for I/O and TPM cycles. A global control word then allows or blocks each cycle type (I/O, TPM, firmware) for the whole decoder. A cycle is accepted only when one window passes the range check and both the window and global permissions for that cycle type.

Configuration is written through a 32-bit write port addressed by a word selector. A request is presented with a one-cycle strobe, a 28-bit address and a 2-bit cycle kind. One clock later the block reports a result strobe, a hit flag and the index of the winning window. When several windows match, the lowest-numbered one wins.

Top module: `hostwin_decoder`

## Requirements
- R1: After reset every configuration word is zero: all windows are disabled, all cycle types are blocked, no request hits, and the result outputs are zero.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `req_valid` was sampled high, and carries the decode of that request.
- R3: The range test is inclusive: a window matches an address A when start <= A <= end, where the first word of window k (selector 1+2k) holds the start in bits 27:0 and the second word (selector 2+2k) holds the end in bits 27:0.
- R4: A window matches only when bit 31 of its first word (enable) is set.
- R5: An I/O cycle (kind 0) hits a window only when bit 30 of its first word is set and bit 3 of the global word (selector 0) is set.
- R6: A TPM cycle (kind 1) hits a window only when bit 29 of its first word is set and bit 2 of the global word is set.
- R7: A firmware cycle (kind 2) needs no per-window permission; it hits any enabled window in range when bit 1 of the global word is set.
- R8: Clearing a global allow bit blocks every window for that cycle type.
- R9: A cycle of kind 3 (reserved) never hits.
- R10: When several windows match, `res_idx` reports the lowest-numbered one.
- R11: Reserved bits (bit 28 of a first word, bits 31:28 of a second word, bits 31:4 and bit 0 of the global word) have no effect on decoding.
- R12: A request decodes against the configuration as it stood before any write made in the same cycle; that write applies to requests from the following cycle onward.
- R13: When `res_valid` is low, `res_hit` and `res_idx` are zero; on a miss `res_idx` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Word selector: 0 global, 1+2k window k start, 2+2k window k end |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 28 | Request address |
| req_kind | input | 2 | Cycle kind: 0 I/O, 1 TPM, 2 firmware, 3 reserved |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_hit | output | 1 | Request fell in an accepted window |
| res_idx | output | 3 | Index of the winning window |

## Verification
A configuration write and a request can land in the same clock, and the write may change the very window the request targets. The bench provokes this both on purpose (disabling a matching window, or narrowing its range, while a request to it is strobed) and by chance in the random phase, where writes and requests are mixed in shared cycles. It judges each such result against its own register model taken before the write, then applies the write to the model so the next request sees the new values.

// File: rtl/hwd_pkg.sv
package hwd_pkg;

  typedef enum logic [1:0] {
    KIND_IO  = 2'd0,
    KIND_TPM = 2'd1,
    KIND_FW  = 2'd2,
    KIND_RSV = 2'd3
  } cyc_kind_e;

  // Bit positions inside a window's first word
  localparam int unsigned WIN_EN_BIT  = 31;
  localparam int unsigned WIN_IO_BIT  = 30;
  localparam int unsigned WIN_TPM_BIT = 29;

  // Bit positions inside the global word
  localparam int unsigned GATE_IO_BIT  = 3;
  localparam int unsigned GATE_TPM_BIT = 2;
  localparam int unsigned GATE_FW_BIT  = 1;

  typedef struct packed {
    logic en;
    logic io_ok;
    logic tpm_ok;
  } win_flags_t;

  typedef struct packed {
    logic io;
    logic tpm;
    logic fw;
  } gate_t;

endpackage

// File: rtl/hwd_cfg_regs.sv
module hwd_cfg_regs
  import hwd_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output win_flags_t           flags_o [NUM_WIN],
  output logic [ADDR_W-1:0]    lo_o    [NUM_WIN],
  output logic [ADDR_W-1:0]    hi_o    [NUM_WIN],
  output gate_t                gate_o
);

  localparam logic [SEL_W-1:0] GLOBAL_SEL = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o <= '0;
    end else if (we_i && sel_i == GLOBAL_SEL) begin
      gate_o.io  <= wdata_i[GATE_IO_BIT];
      gate_o.tpm <= wdata_i[GATE_TPM_BIT];
      gate_o.fw  <= wdata_i[GATE_FW_BIT];
    end
  end

  // Global write takes effect on the next cycle
  gate_update_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel_i == GLOBAL_SEL) |=>
      (gate_o.io == $past(wdata_i[GATE_IO_BIT]) && gate_o.fw == $past(wdata_i[GATE_FW_BIT])));

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam logic [SEL_W-1:0] SEL_LO = SEL_W'(1 + 2 * k);
    localparam logic [SEL_W-1:0] SEL_HI = SEL_W'(2 + 2 * k);

    always_ff @(posedge clk) begin
      if (rst) begin
        flags_o[k] <= '0;
        lo_o[k]    <= '0;
      end else if (we_i && sel_i == SEL_LO) begin
        flags_o[k].en     <= wdata_i[WIN_EN_BIT];
        flags_o[k].io_ok  <= wdata_i[WIN_IO_BIT];
        flags_o[k].tpm_ok <= wdata_i[WIN_TPM_BIT];
        lo_o[k]           <= wdata_i[ADDR_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_o[k] <= '0;
      end else if (we_i && sel_i == SEL_HI) begin
        hi_o[k] <= wdata_i[ADDR_W-1:0];
      end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (flags_o[k] == '0 && lo_o[k] == '0 && hi_o[k] == '0));
  end

endmodule

// File: rtl/hwd_window_match.sv
module hwd_window_match
  import hwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 28
) (
  input  win_flags_t          flags_i,
  input  logic [ADDR_W-1:0]   lo_i,
  input  logic [ADDR_W-1:0]   hi_i,
  input  gate_t               gate_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  cyc_kind_e           kind_i,
  output logic                match_o
);

  logic permitted;
  logic in_range;

  always_comb begin
    unique case (kind_i)
      KIND_IO:  permitted = flags_i.io_ok  & gate_i.io;
      KIND_TPM: permitted = flags_i.tpm_ok & gate_i.tpm;
      KIND_FW:  permitted = gate_i.fw;
      default:  permitted = 1'b0;
    endcase
  end

  assign in_range = (addr_i >= lo_i) && (addr_i <= hi_i);
  assign match_o  = flags_i.en & permitted & in_range;

endmodule

// File: rtl/hwd_prio_pick.sv
module hwd_prio_pick #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_WIN-1:0] match_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    any_o = |match_i;
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  // R10
  pick_is_match_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> match_i[idx_o]);

  // R10
  pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> ((match_i & ((NUM_WIN'(1) << idx_o) - NUM_WIN'(1))) == '0));

endmodule

// File: rtl/hostwin_decoder.sv
module hostwin_decoder
  import hwd_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = $clog2(2 * NUM_WIN + 1),
  parameter int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx
);

  win_flags_t         flags [NUM_WIN];
  logic [ADDR_W-1:0]  lo    [NUM_WIN];
  logic [ADDR_W-1:0]  hi    [NUM_WIN];
  gate_t              gate;
  logic [NUM_WIN-1:0] match;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;
  cyc_kind_e          kind;

  assign kind = cyc_kind_e'(req_kind);

  hwd_cfg_regs #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .sel_i(cfg_sel), .wdata_i(cfg_wdata),
    .flags_o(flags), .lo_o(lo), .hi_o(hi), .gate_o(gate)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_match
    hwd_window_match #(.ADDR_W(ADDR_W)) u_match (
      .flags_i(flags[k]), .lo_i(lo[k]), .hi_i(hi[k]), .gate_i(gate),
      .addr_i(req_addr), .kind_i(kind), .match_o(match[k])
    );
  end

  hwd_prio_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .match_i(match), .any_o(any_hit), .idx_o(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= req_valid;
      res_hit   <= req_valid & any_hit;
      res_idx   <= (req_valid & any_hit) ? win_idx : '0;
    end
  end

  // R2
  res_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(req_valid)));

  // R13
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!res_valid || !res_hit) |-> (res_idx == '0 && (res_valid || !res_hit)));

  // R9
  rsv_kind_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=> !res_hit);

  // R4
  disabled_win_miss_chk: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> $past(flags[0].en || flags[1].en || flags[2].en ||
                      flags[3].en || flags[4].en || flags[5].en));

endmodule

// File: tb/hostwin_decoder_test.sv
module hostwin_decoder_test;

  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [27:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        res_valid;
  logic        res_hit;
  logic [2:0]  res_idx;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] m_glob;
  logic [31:0] m_w0 [NW];
  logic [31:0] m_w1 [NW];

  always #2.5 clk = ~clk;

  hostwin_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
  );

  function automatic logic [3:0] model_decode(logic [27:0] a, logic [1:0] k);
    for (int i = 0; i < NW; i++) begin
      logic perm;
      case (k)
        2'd0: perm = m_w0[i][30] & m_glob[3];
        2'd1: perm = m_w0[i][29] & m_glob[2];
        2'd2: perm = m_glob[1];
        default: perm = 1'b0;
      endcase
      if (m_w0[i][31] && perm && a >= m_w0[i][27:0] && a <= m_w1[i][27:0])
        return {1'b1, 3'(i)};
    end
    return 4'b0000;
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic model_write(logic [3:0] s, logic [31:0] d);
    if (s == 0) m_glob = d;
    else if (s <= 2 * NW) begin
      if (s[0]) m_w0[(s - 1) / 2] = d;
      else      m_w1[(s - 2) / 2] = d;
    end
  endtask

  task automatic wr(logic [3:0] s, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(s, d);
  endtask

  // Optionally a write in the same cycle as the request (R12)
  task automatic req(string rq, logic [27:0] a, logic [1:0] k,
                     bit with_wr = 0, logic [3:0] s = 0, logic [31:0] d = 0);
    logic [3:0] e;
    e = model_decode(a, k);
    req_valid = 1'b1; req_addr = a; req_kind = k;
    if (with_wr) begin cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d; end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    if (with_wr) model_write(s, d);
    check({rq, " R2 valid"}, 32'(res_valid), 32'd1);
    check(rq, {28'd0, res_hit, res_idx}, {28'd0, e});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R13 idle", {28'd0, res_valid, res_hit, res_idx}, 32'd0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    m_glob = '0;
    for (int i = 0; i < NW; i++) begin m_w0[i] = '0; m_w1[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {28'd0, res_valid, res_hit, res_idx}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    req("R1 no hit after reset io", 28'h0, 2'd0);
    req("R1 no hit after reset fw", 28'h0, 2'd2);

    // Window 0: 0x100..0x1FF, I/O only
    wr(4'd0, 32'h0000_000E);
    wr(4'd1, 32'hC000_0100);
    wr(4'd2, 32'h0000_01FF);
    req("R3 start edge", 28'h100, 2'd0);
    check("R3 start hit", 32'(res_hit), 32'd1);
    req("R3 end edge", 28'h1FF, 2'd0);
    req("R3 below start", 28'h0FF, 2'd0);
    req("R3 above end", 28'h200, 2'd0);
    req("R6 tpm not permitted", 28'h150, 2'd1);
    wr(4'd1, 32'hA000_0100);
    req("R6 tpm permitted", 28'h150, 2'd1);
    req("R5 io not permitted", 28'h150, 2'd0);
    wr(4'd1, 32'h8000_0100);
    req("R7 fw no window bits", 28'h150, 2'd2);
    check("R7 fw hit", 32'(res_hit), 32'd1);
    wr(4'd0, 32'h0000_000C);
    req("R8 fw blocked", 28'h150, 2'd2);
    wr(4'd1, 32'hC000_0100);
    wr(4'd0, 32'h0000_0006);
    req("R8 io blocked", 28'h150, 2'd0);
    wr(4'd0, 32'h0000_000E);
    req("R9 reserved kind", 28'h150, 2'd3);
    idle_check();

    // Overlap: windows 1 and 3 cover 0x400
    wr(4'd3, 32'hC000_0380); wr(4'd4, 32'h0000_0480);
    wr(4'd7, 32'hC000_0400); wr(4'd8, 32'h0000_0400);
    req("R10 lowest wins", 28'h400, 2'd0);
    check("R10 idx", 32'(res_idx), 32'd1);
    wr(4'd3, 32'h4000_0380);
    req("R4 disabled skip", 28'h400, 2'd0);
    check("R4 idx", 32'(res_idx), 32'd3);

    // Reserved bits
    wr(4'd0, 32'hFFFF_FFF1);
    req("R11 global reserved", 28'h150, 2'd0);
    wr(4'd0, 32'h0000_000E);
    wr(4'd1, 32'hD000_0100); wr(4'd2, 32'hF000_01FF);
    req("R11 window reserved", 28'h1FF, 2'd0);
    check("R11 hit", {31'd0, res_hit}, 32'd1);

    // Same-cycle write
    req("R12 old config used", 28'h120, 2'd0, 1, 4'd1, 32'h0000_0100);
    check("R12 still hit", 32'(res_hit), 32'd1);
    req("R12 new config used", 28'h120, 2'd0);
    check("R12 now miss", 32'(res_hit), 32'd0);
    req("R12 end narrowed", 28'h3A0, 2'd0, 1, 4'd4, 32'h0000_0390);
    req("R12 after narrow", 28'h3A0, 2'd0);
    idle_check();

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) begin
        logic [27:0] st;
        int w;
        w = $urandom % NW;
        st = 28'($urandom % 200);
        wr(4'(1 + 2 * w), {$urandom % 8 == 0 ? 1'b0 : 1'b1, 2'($urandom), 1'($urandom), st});
        wr(4'(2 + 2 * w), {4'($urandom), st + 28'($urandom % 80)});
      end else if (r == 1) begin
        wr(4'd0, ($urandom % 4 == 0) ? $urandom : 32'h0000_000E);
      end else if (r == 2) begin
        int w;
        w = $urandom % NW;
        req("R12 random same-cycle", 28'($urandom % 300), 2'($urandom), 1,
            4'(1 + 2 * w), {1'($urandom), 2'b11, 1'b0, 28'($urandom % 200)});
      end else if (r == 3) begin
        idle_check();
      end else begin
        req("R3 random decode", 28'($urandom % 300), 2'($urandom));
      end
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule